// File: doc/BRIEF.md
# Auto-Transfer Clocked Serial Interface

This block is a byte-oriented synchronous serial port that moves a whole block of bytes between a small local buffer and the serial lines on its own. Software first fills the buffer through a simple write port and programs the length as "bytes minus one". It then pulses `start`. The engine sends each stored byte on `sdo` and captures the matching received byte from `sdi`. It writes the received byte back into the same buffer slot, working upward from slot 0. When the last byte is done it drops `busy` and raises `done_irq` for one cycle.

The shift clock comes from one of two sources. In internal mode, a 16-cycle period is generated and driven on `sck_out`: eight cycles low, then eight high, idling high. In external mode, the clock on `sck_in` is used after a two-flop synchroniser. Each byte is 8 bits, sent MSB or LSB first. Input is sampled on the rising shift-clock edge and output advances on the falling edge.

An optional chip-select slave mode uses an active-low select input. While the select is high, the data output and the clock driver are released and shift-clock edges are ignored. If the select rises in the middle of a byte, the transfer is abandoned and the partial byte is dropped.

Top module: `blk_serial_xfer`

## Requirements
- R1: After reset `busy`, `done_irq` and `xfer_err` are 0 and `sck_out` is 1. With `cfg_cs_mode`=0, `sdo_oe` is 1. With `cfg_ext_clk`=0, `sck_oe` is 1.
- R2: A `start` pulse while idle transfers `cfg_len_m1`+1 bytes (1 to 32). Byte k is taken from buffer slot k, starting at slot 0, and the byte received in its place is written back to slot k. Slots at or above the length keep their contents.
- R3: With `cfg_msb_first`=1, bit 7 is sent and received first. With `cfg_msb_first`=0, bit 0 is sent and received first. The setting applies to both `sdo` and `sdi`.
- R4: With `cfg_ext_clk`=0, `sck_out` is low for the first 8 cycles after the start edge and high for the next 8, repeating with a period of 16. `busy` stays high for exactly 128·N−8 cycles for N bytes. `sck_out` is 1 whenever idle, and `sdo` does not change while `sck_out` is high.
- R5: With `cfg_ext_clk`=1, `sck_oe` is 0. The shift clock is `sck_in` after two synchroniser flops. `sdi` is sampled on its rising edges and `sdo` advances on its falling edges. The first bit of a byte is on `sdo` before that byte's first rising edge.
- R6: When the last byte completes, `busy` falls and `done_irq` is high for exactly one cycle in the same cycle.
- R7: With `cfg_cs_mode`=1 and `cs_n` high (after synchronisation), `sdo_oe` and `sck_oe` are 0 and shift-clock edges are ignored. A transfer paused at a byte boundary resumes when `cs_n` goes low again.
- R8: With `cfg_cs_mode`=1, a rise of `cs_n` after at least one bit of a byte has been sampled aborts the transfer. `busy` falls, `xfer_err` becomes 1, no `done_irq` is raised, and the partial byte is not written.
- R9: A `start` pulse or a buffer write from the write port while `busy` is high is ignored.
- R10: `xfer_err` stays set until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ext_clk | input | 1 | 1 = shift clock from `sck_in`, 0 = generated internally |
| cfg_msb_first | input | 1 | 1 = MSB first, 0 = LSB first |
| cfg_cs_mode | input | 1 | 1 = chip-select slave mode enabled |
| cfg_len_m1 | input | 5 | Block length minus one |
| start | input | 1 | Start pulse, accepted only when idle |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle pulse at normal completion |
| xfer_err | output | 1 | Set by a mid-byte chip-select abort |
| buf_we | input | 1 | Buffer write strobe (ignored while busy) |
| buf_addr | input | 5 | Buffer slot for write and read |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer read data at `buf_addr` (combinational) |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Drive enable for `sck_out` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| cs_n | input | 1 | Active-low chip select |

## Verification
The hardest case to reach from the ports is a chip-select rise that falls on a byte boundary, where the engine must hold a pending buffer reload without aborting. The sibling case is a rise three bits into a byte, which must abort and leave the buffer slot untouched. The bench plays the external master itself. It drives `sck_in` and `sdi` bit by bit, so it can raise `cs_n` exactly after a completed byte or after a chosen number of sampled bits. It also toggles `sck_in` while deselected, to show that those edges neither shift nor reload the data. In internal-clock mode a per-cycle model predicts `busy`, `sck_out` and `done_irq` on every clock while the bench acts as the slave.

// File: rtl/ser_xfer_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the block-transfer serial port.
// Assumes: byte-wide frames, buffer depth a power of two.
package ser_xfer_pkg;
    localparam int BYTE_W_DEF    = 8;
    localparam int MAX_BYTES_DEF = 32;
    localparam int HALF_DEF      = 8;
    localparam int SYNC_DEF      = 2;

    // Shift-clock event pair produced by the clock selector.
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_evt_t;

    // Engine run state.
    typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } run_state_t;
endpackage

// File: rtl/ser_xfer_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes: each bit is independent; reset value is given per bit.
module ser_xfer_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ser_xfer_clkgen.sv
`timescale 1ns/1ps
// Shift-clock source: internal divider or synchronised external clock.
// Produces one-cycle rise/fall events and the generated clock level.
// Assumes: ext_sck is already synchronised; en gates all events.
module ser_xfer_clkgen
    import ser_xfer_pkg::*;
#(
    parameter int HALF = HALF_DEF,
    parameter int PH_W = $clog2(2*HALF)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     en,
    input  logic     ext_sel,
    input  logic     ext_sck,
    output sck_evt_t evt,
    output logic     sck_gen
);
    localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2*HALF - 1);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HALF);

    logic [PH_W-1:0] ph;
    logic            ext_prev;
    sck_evt_t        int_evt;
    sck_evt_t        ext_evt;

    // Phase counter of the internal divider; parked at 0 when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ph <= '0;
        else if (!run)    ph <= '0;
        else if (en)      ph <= (ph == PH_LAST) ? '0 : ph + PH_W'(1);
    end

    // Previous level of the external clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b1;
        else        ext_prev <= ext_sck;
    end

    // Event decode for both sources.
    always_comb begin
        int_evt.rise = run && en && (ph == PH_RISE);
        int_evt.fall = run && en && (ph == PH_LAST);
        ext_evt.rise = en && ext_sck && !ext_prev;
        ext_evt.fall = en && !ext_sck && ext_prev;
    end

    assign evt     = ext_sel ? ext_evt : int_evt;
    assign sck_gen = ext_sel || !run || (ph >= PH_HIGH);
endmodule

// File: rtl/ser_xfer_buf.sv
`timescale 1ns/1ps
// Local transfer buffer with one engine port and one host port.
// The engine write wins; host writes are dropped while a transfer runs.
// Assumes: contents are undefined until written (no reset on storage).
module ser_xfer_buf #(
    parameter int DEPTH = 32,
    parameter int W = 8,
    parameter int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          busy,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [W-1:0]  eng_wdata,
    output logic [W-1:0]  eng_rdata,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [W-1:0]  host_wdata,
    output logic [W-1:0]  host_rdata
);
    logic [W-1:0]     mem [DEPTH];
    logic [DEPTH-1:0] row_eng;
    logic [DEPTH-1:0] row_host;

    // Per-row write decode for both ports.
    generate
        for (genvar r = 0; r < DEPTH; r++) begin : g_row
            assign row_eng[r]  = eng_we && (eng_addr == AW'(r));
            assign row_host[r] = host_we && !busy && (host_addr == AW'(r));
        end
    endgenerate

    // Storage update, engine port first.
    always_ff @(posedge clk) begin
        for (int r = 0; r < DEPTH; r++) begin
            if (row_eng[r])       mem[r] <= eng_wdata;
            else if (row_host[r]) mem[r] <= host_wdata;
        end
    end

    assign eng_rdata  = mem[eng_addr];
    assign host_rdata = mem[host_addr];
endmodule

// File: rtl/ser_xfer_engine.sv
`timescale 1ns/1ps
// Block-transfer shift engine: walks the buffer, shifts bytes out and in,
// counts bytes, finishes with a done pulse or aborts on a mid-byte deselect.
// Assumes: rise and fall events never coincide; buffer read is combinational.
module ser_xfer_engine
    import ser_xfer_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF,
    parameter int MAX_BYTES = MAX_BYTES_DEF,
    parameter int IDX_W = $clog2(MAX_BYTES),
    parameter int CNT_W = IDX_W + 1,
    parameter int BIT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  len_m1,
    input  logic              msb_first,
    input  logic              cs_mode,
    input  logic              cs_high,
    input  sck_evt_t          evt,
    input  logic              sdi_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              sdo
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    run_state_t        st;
    logic [CNT_W-1:0]  remain;
    logic [BIT_W-1:0]  bits_in;
    logic              need_load;
    logic              cs_prev;
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] rx_nxt;
    logic [BYTE_W-1:0] tx_nxt;
    logic              last_bit;
    logic              abort;

    // Next-value shifts for both bit orders.
    always_comb begin
        if (msb_first) begin
            rx_nxt = {rx_sr[BYTE_W-2:0], sdi_s};
            tx_nxt = {tx_sr[BYTE_W-2:0], 1'b0};
        end else begin
            rx_nxt = {sdi_s, rx_sr[BYTE_W-1:1]};
            tx_nxt = {1'b0, tx_sr[BYTE_W-1:1]};
        end
    end

    assign busy     = (st == ST_RUN);
    assign last_bit = (bits_in == LAST_BIT);
    assign abort    = busy && cs_mode && cs_high && !cs_prev && (bits_in != '0);
    assign wr_en    = busy && !abort && evt.rise && last_bit;
    assign wr_data  = rx_nxt;
    assign sdo      = msb_first ? tx_sr[BYTE_W-1] : tx_sr[0];

    // Remember the select level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_prev <= 1'b1;
        else        cs_prev <= cs_high;
    end

    // Transfer control, byte counting and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            idx       <= '0;
            remain    <= '0;
            bits_in   <= '0;
            need_load <= 1'b0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    st        <= ST_RUN;
                    idx       <= '0;
                    remain    <= CNT_W'(len_m1) + CNT_W'(1);
                    bits_in   <= '0;
                    need_load <= 1'b0;
                    tx_sr     <= rd_data;
                    err       <= 1'b0;
                end
            end else if (abort) begin
                st        <= ST_IDLE;
                err       <= 1'b1;
                idx       <= '0;
                bits_in   <= '0;
                need_load <= 1'b0;
            end else begin
                if (evt.rise) begin
                    rx_sr <= rx_nxt;
                    if (last_bit) begin
                        bits_in <= '0;
                        remain  <= remain - CNT_W'(1);
                        if (remain == CNT_W'(1)) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                            idx  <= '0;
                        end else begin
                            idx       <= idx + IDX_W'(1);
                            need_load <= 1'b1;
                        end
                    end else begin
                        bits_in <= bits_in + BIT_W'(1);
                    end
                end
                if (evt.fall) begin
                    if (need_load) begin
                        tx_sr     <= rd_data;
                        need_load <= 1'b0;
                    end else if (bits_in != '0) begin
                        tx_sr <= tx_nxt;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/blk_serial_xfer.sv
`timescale 1ns/1ps
// Top of the block-transfer clocked serial port: synchronises the pins,
// selects the shift clock, runs the engine over the local buffer and
// derives the output enables for chip-select slave mode.
// Assumes: configuration inputs are held steady during a transfer.
module blk_serial_xfer
    import ser_xfer_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF,
    parameter int MAX_BYTES = MAX_BYTES_DEF,
    parameter int HALF_PERIOD = HALF_DEF,
    parameter int SYNC_STAGES = SYNC_DEF,
    parameter int IDX_W = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ext_clk,
    input  logic              cfg_msb_first,
    input  logic              cfg_cs_mode,
    input  logic [IDX_W-1:0]  cfg_len_m1,
    input  logic              start,
    output logic              busy,
    output logic              done_irq,
    output logic              xfer_err,
    input  logic              buf_we,
    input  logic [IDX_W-1:0]  buf_addr,
    input  logic [BYTE_W-1:0] buf_wdata,
    output logic [BYTE_W-1:0] buf_rdata,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              cs_n
);
    localparam int PIN_W = 3;
    localparam logic [PIN_W-1:0] PIN_RST = 3'b101;

    logic [PIN_W-1:0]  pins_s;
    logic              sck_s;
    logic              sdi_s;
    logic              cs_s;
    logic              deselect;
    sck_evt_t          evt;
    logic [IDX_W-1:0]  eng_idx;
    logic              eng_we;
    logic [BYTE_W-1:0] eng_wd;
    logic [BYTE_W-1:0] eng_rd;

    ser_xfer_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sdi, sck_in}), .q(pins_s)
    );

    assign sck_s    = pins_s[0];
    assign sdi_s    = pins_s[1];
    assign cs_s     = pins_s[2];
    assign deselect = cfg_cs_mode && cs_s;

    ser_xfer_clkgen #(.HALF(HALF_PERIOD)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .en(!deselect),
        .ext_sel(cfg_ext_clk), .ext_sck(sck_s), .evt(evt), .sck_gen(sck_out)
    );

    ser_xfer_engine #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .len_m1(cfg_len_m1),
        .msb_first(cfg_msb_first), .cs_mode(cfg_cs_mode), .cs_high(cs_s),
        .evt(evt), .sdi_s(sdi_s), .rd_data(eng_rd), .idx(eng_idx),
        .wr_en(eng_we), .wr_data(eng_wd), .busy(busy), .done(done_irq),
        .err(xfer_err), .sdo(sdo)
    );

    ser_xfer_buf #(.DEPTH(MAX_BYTES), .W(BYTE_W)) u_buf (
        .clk(clk), .busy(busy), .eng_we(eng_we), .eng_addr(eng_idx),
        .eng_wdata(eng_wd), .eng_rdata(eng_rd), .host_we(buf_we),
        .host_addr(buf_addr), .host_wdata(buf_wdata), .host_rdata(buf_rdata)
    );

    assign sdo_oe = !deselect;
    assign sck_oe = !cfg_ext_clk && !deselect;
endmodule

// File: rtl/ser_xfer_chk.sv
`timescale 1ns/1ps
// Property checker for blk_serial_xfer, attached by bind below.
// Assumes: configuration is steady while busy.
module ser_xfer_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done_irq,
    input logic xfer_err,
    input logic cfg_ext_clk,
    input logic sck_out,
    input logic sdo
);
    assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (!busy && $past(busy)));

    assert_start_accepted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_start_clears_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !xfer_err);

    assert_idle_sck_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_out);

    assert_sdo_hold_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ext_clk && busy && $past(busy) && sck_out && $past(sck_out)) |-> $stable(sdo));

    assert_abort_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_err) |-> (!busy && !done_irq && $past(busy)));
endmodule

bind blk_serial_xfer ser_xfer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done_irq(done_irq),
    .xfer_err(xfer_err), .cfg_ext_clk(cfg_ext_clk), .sck_out(sck_out), .sdo(sdo)
);

// File: tb/sim_blk_serial_xfer.sv
`timescale 1ns/1ps
// Bench: behavioural master/slave model with a shadow buffer.
module sim_blk_serial_xfer;
    localparam int HB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ext_clk = 1'b0, cfg_msb_first = 1'b1, cfg_cs_mode = 1'b0;
    logic [4:0] cfg_len_m1 = '0;
    logic       start = 1'b0;
    logic       busy, done_irq, xfer_err;
    logic       buf_we = 1'b0;
    logic [4:0] buf_addr = '0;
    logic [7:0] buf_wdata = '0;
    logic [7:0] buf_rdata;
    logic       sck_in = 1'b1, sck_out, sck_oe, sdi = 1'b0, sdo, sdo_oe, cs_n = 1'b0;

    int checks = 0, errors = 0, done_cnt = 0;
    logic [7:0] shadow [32];

    blk_serial_xfer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_msb_first(cfg_msb_first),
        .cfg_cs_mode(cfg_cs_mode), .cfg_len_m1(cfg_len_m1), .start(start), .busy(busy),
        .done_irq(done_irq), .xfer_err(xfer_err), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .sck_in(sck_in), .sck_out(sck_out),
        .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .cs_n(cs_n)
    );

    always #2 clk = ~clk;

    always @(negedge clk) if (rst_n && done_irq) done_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int s);
        return 8'((i * 53 + s) & 255);
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(input int a, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = 5'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic verify_buf(input string req);
        for (int a = 0; a < 32; a++) begin
            buf_addr = 5'(a);
            #1;
            chk(buf_rdata === shadow[a], req, buf_rdata, shadow[a]);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic master_bit(input logic b, output logic got);
        sck_in = 1'b0; sdi = b;
        wait_n(HB);
        got = sdo;
        sck_in = 1'b1;
        wait_n(HB);
    endtask

    task automatic master_byte(input int i, input bit msb, input logic [7:0] mb);
        logic got;
        for (int b = 0; b < 8; b++) begin
            master_bit(msb ? mb[7-b] : mb[b], got);
            chk(got === (msb ? shadow[i][7-b] : shadow[i][b]), "R3 R5 sdo bit", got,
                msb ? shadow[i][7-b] : shadow[i][b]);
        end
        shadow[i] = mb;
    endtask

    task automatic ext_run(input int n, input bit msb, input bit mid, input int seed);
        int d0;
        logic [7:0] keep31;
        cfg_ext_clk = 1'b1; cfg_msb_first = msb; cfg_len_m1 = 5'(n - 1);
        d0 = done_cnt;
        pulse_start();
        chk(busy === 1'b1, "R2 busy after start", busy, 1);
        chk(xfer_err === 1'b0, "R10 err cleared by start", xfer_err, 0);
        chk(sck_oe === 1'b0, "R5 sck released", sck_oe, 0);
        for (int i = 0; i < n; i++) begin
            master_byte(i, msb, pat(i, seed));
            if (mid && i == 0 && n > 1) begin
                keep31 = shadow[31];
                cpu_write(31, ~keep31);
                cfg_len_m1 = 5'd0;
                pulse_start();
                cfg_len_m1 = 5'(n - 1);
            end
        end
        wait_n(4);
        chk(busy === 1'b0, "R6 busy cleared", busy, 0);
        chk(done_cnt == d0 + 1, "R6 one done pulse", done_cnt - d0, 1);
        verify_buf(mid ? "R9 R2 buffer" : "R2 buffer");
    endtask

    task automatic int_run(input int n, input bit msb, input int seed);
        int t, by, bi, d0;
        logic prev, eb, es;
        logic [7:0] sb;
        t = 128 * n - 8; by = 0; bi = 0; prev = 1'b1; d0 = done_cnt;
        cfg_ext_clk = 1'b0; cfg_msb_first = msb; cfg_cs_mode = 1'b0; cfg_len_m1 = 5'(n - 1);
        pulse_start();
        for (int k = 0; k <= t + 3; k++) begin
            eb = (k < t);
            es = eb ? ((k % 16) >= 8) : 1'b1;
            chk(busy === eb, "R4 busy length", busy, eb);
            chk(sck_out === es, "R4 sck shape", sck_out, es);
            chk(done_irq === (k == t), "R6 done timing", done_irq, k == t);
            sb = pat(by, seed);
            if (!sck_out && prev && by < n) sdi = msb ? sb[7-bi] : sb[bi];
            if (sck_out && !prev && by < n) begin
                chk(sdo === (msb ? shadow[by][7-bi] : shadow[by][bi]), "R3 sdo bit", sdo,
                    msb ? shadow[by][7-bi] : shadow[by][bi]);
                bi++;
                if (bi == 8) begin shadow[by] = sb; by++; bi = 0; end
            end
            prev = sck_out;
            @(negedge clk);
        end
        chk(done_cnt == d0 + 1, "R6 one done pulse", done_cnt - d0, 1);
        verify_buf("R2 buffer");
    endtask

    task automatic cs_pause_run(input int seed);
        int d0;
        logic got;
        cfg_cs_mode = 1'b1; cfg_ext_clk = 1'b1; cfg_msb_first = 1'b1; cfg_len_m1 = 5'd1;
        cs_n = 1'b0; wait_n(4);
        d0 = done_cnt;
        pulse_start();
        master_byte(0, 1'b1, pat(0, seed));
        cs_n = 1'b1; wait_n(4);
        chk(busy === 1'b1, "R7 paused at boundary", busy, 1);
        chk(xfer_err === 1'b0, "R7 no abort at boundary", xfer_err, 0);
        chk(sdo_oe === 1'b0, "R7 sdo released", sdo_oe, 0);
        master_bit(1'b1, got);
        master_bit(1'b0, got);
        cs_n = 1'b0; wait_n(4);
        chk(sdo_oe === 1'b1, "R7 sdo driven", sdo_oe, 1);
        master_byte(1, 1'b1, pat(1, seed));
        wait_n(4);
        chk(busy === 1'b0, "R7 resumed and done", busy, 0);
        chk(done_cnt == d0 + 1, "R7 done once", done_cnt - d0, 1);
        verify_buf("R7 buffer");
    endtask

    task automatic abort_run();
        int d0;
        logic got;
        cfg_cs_mode = 1'b1; cfg_ext_clk = 1'b1; cfg_msb_first = 1'b0; cfg_len_m1 = 5'd1;
        cs_n = 1'b0; wait_n(4);
        d0 = done_cnt;
        pulse_start();
        for (int b = 0; b < 3; b++) master_bit(~shadow[0][b], got);
        cs_n = 1'b1; wait_n(5);
        chk(busy === 1'b0, "R8 abort clears busy", busy, 0);
        chk(xfer_err === 1'b1, "R8 error set", xfer_err, 1);
        chk(done_cnt == d0, "R8 no done", done_cnt - d0, 0);
        buf_addr = 5'd0; #1;
        chk(buf_rdata === shadow[0], "R8 partial byte dropped", buf_rdata, shadow[0]);
        wait_n(3);
        chk(xfer_err === 1'b1, "R10 error held", xfer_err, 1);
        cs_n = 1'b0; wait_n(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(done_irq === 1'b0, "R1 done", done_irq, 0);
        chk(xfer_err === 1'b0, "R1 err", xfer_err, 0);
        chk(sck_out === 1'b1, "R1 sck idle", sck_out, 1);
        chk(sdo_oe === 1'b1, "R1 sdo_oe", sdo_oe, 1);
        chk(sck_oe === 1'b1, "R1 sck_oe", sck_oe, 1);
        for (int a = 0; a < 32; a++) begin
            shadow[a] = 8'((a * 29 + 7) & 255);
            cpu_write(a, shadow[a]);
        end
        verify_buf("R2 host fill");
        int_run(3, 1'b1, 11);
        int_run(1, 1'b0, 90);
        ext_run(2, 1'b1, 1'b1, 33);
        ext_run(3, 1'b0, 1'b0, 71);
        ext_run(32, 1'b1, 1'b0, 5);
        cfg_ext_clk = 1'b0; cfg_cs_mode = 1'b1; cs_n = 1'b1; wait_n(4);
        chk(sck_oe === 1'b0, "R7 sck released", sck_oe, 0);
        chk(sdo_oe === 1'b0, "R7 sdo released", sdo_oe, 0);
        cs_n = 1'b0; wait_n(4);
        chk(sck_oe === 1'b1, "R7 sck driven", sck_oe, 1);
        chk(sdo_oe === 1'b1, "R7 sdo driven", sdo_oe, 1);
        cs_pause_run(120);
        abort_run();
        ext_run(1, 1'b1, 1'b0, 200);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule